// File: doc/BRIEF.md
# GRS Mantissa Rounding Stage

This block rounds an unpacked floating-point mantissa that carries two extra low-order bits, guard and round, with a sticky bit supplied on its own input. It decides from the sign and a 2-bit rounding-mode field whether to increment. It then drops the two extra bits and adds one at the new least-significant position when required. The stage is purely combinational and sits between a normaliser and a packer in a floating-point datapath.

The caller gets four things back. The first is the rounded mantissa, one bit wider than the shifted input so that a carry-out to 2.0 is visible. The second is a rounded-up indication. The third is an inexact flag together with a fraction-inexact flag. The fourth is a fraction-rounded flag. Renormalising after a carry-out and all exponent handling stay with the caller.

Top module: `grs_round_unit`

## Requirements
- R1: When guard (mant_i bit 1), round (mant_i bit 0) and sticky_i are all zero, mant_o equals mant_i shifted right by two with a zero top bit, and every flag output is low, whatever the mode.
- R2: When any of guard, round or sticky is set, inexact_o and frac_inexact_o are both high; otherwise both are low.
- R3: With mode_i = 2'b00 (nearest), an increment happens only when guard is set and at least one of these holds: round is set, sticky is set, or bit 0 of the shifted mantissa is 1. A tie therefore goes to even.
- R4: With mode_i = 2'b01 (toward zero), no increment ever happens.
- R5: With mode_i = 2'b10 (toward plus infinity), an increment happens exactly when the result is inexact and sign_i is 0.
- R6: With mode_i = 2'b11 (toward minus infinity), an increment happens exactly when the result is inexact and sign_i is 1.
- R7: On an increment, mant_o equals the shifted mantissa plus one with the carry propagated through every bit, and round_up_o and frac_round_o are both high. Without an increment both are low.
- R8: When the shifted mantissa is all ones and an increment happens, mant_o has only its top bit set (the value 2.0), and the caller must fix it.
- R9: The sticky bit is never merged into mant_o. A result that is not incremented carries no trace of sticky, and the shift is always exactly two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mant_i | input | MANT_W+2 | Mantissa with guard (bit 1) and round (bit 0) appended |
| sticky_i | input | 1 | OR of all bits shifted out below round |
| mant_o | output | MANT_W+1 | Rounded mantissa, top bit is the carry-out |
| round_up_o | output | 1 | High when the mantissa was incremented |
| inexact_o | output | 1 | High when any discarded bit was nonzero |
| frac_inexact_o | output | 1 | Fraction-inexact flag, raised together with inexact_o |
| frac_round_o | output | 1 | Fraction-rounded flag, raised on an increment |

## Verification
The bench targets several corner cases, each of which a specific bug would expose:
- Ties in nearest mode with an even and with an odd low bit. A design that rounds half up instead of to even fails on the even tie.
- Guard clear with round and sticky set. A nearest-mode decision that wrongly uses the round bit would increment here.
- Sticky-only inexactness. This catches a design that ignores sticky in the flags or leaks it into the mantissa.
- An all-ones mantissa with an increment. This shows whether the carry reaches the extra top bit or is lost.
- Both signs under the two directed-infinity modes. This exposes a swapped sign test.

Long random runs across all four modes then cover the remaining mixes.

// File: rtl/grs_round_pkg.sv
package grs_round_pkg;
  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_PINF = 2'b10,
    RND_MINF = 2'b11
  } rnd_mode_e;
endpackage

// File: rtl/grs_round_decide.sv
module grs_round_decide
  import grs_round_pkg::*;
(
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  input  logic      guard_i,
  input  logic      rbit_i,
  input  logic      sticky_i,
  input  logic      lsb_i,
  output logic      inc_o,
  output logic      inexact_o
);
  logic lost;

  always_comb begin
    lost = guard_i | rbit_i | sticky_i;
    unique case (mode_i)
      RND_ZERO: inc_o = 1'b0;
      RND_PINF: inc_o = lost & ~sign_i;
      RND_MINF: inc_o = lost & sign_i;
      default:  inc_o = guard_i & (rbit_i | sticky_i | lsb_i);
    endcase
    inexact_o = lost;
  end

  always_comb begin
    p_exact_quiet_r1: assert (guard_i | rbit_i | sticky_i || (!inc_o && !inexact_o))
      else $error("exact input raised a flag or increment");
    p_rz_never_r4: assert (mode_i != RND_ZERO || !inc_o)
      else $error("toward-zero incremented");
    p_near_guard_r3: assert (mode_i != RND_NEAR || guard_i || !inc_o)
      else $error("nearest incremented with guard clear");
  end
endmodule

// File: rtl/grs_round_incr.sv
module grs_round_incr #(
  parameter int W = 53
) (
  input  logic [W-1:0] a_i,
  input  logic         inc_i,
  output logic [W:0]   sum_o
);
  logic [W:0] carry;

  assign carry[0] = inc_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]     = a_i[i] ^ carry[i];
    assign carry[i+1]   = a_i[i] & carry[i];
  end

  assign sum_o[W] = carry[W];

  always_comb begin
    p_sum_r7: assert (sum_o == ({1'b0, a_i} + {{W{1'b0}}, inc_i}))
      else $error("carry chain mismatch");
  end
endmodule

// File: rtl/grs_round_unit.sv
module grs_round_unit
  import grs_round_pkg::*;
#(
  parameter int MANT_W = 53
) (
  input  logic              sign_i,
  input  logic [1:0]        mode_i,
  input  logic [MANT_W+1:0] mant_i,
  input  logic              sticky_i,
  output logic [MANT_W:0]   mant_o,
  output logic              round_up_o,
  output logic              inexact_o,
  output logic              frac_inexact_o,
  output logic              frac_round_o
);
  localparam int IN_W = MANT_W + 2;

  logic [MANT_W-1:0] base;
  logic              inc;
  logic              inx;
  rnd_mode_e         mode;

  assign base = mant_i[IN_W-1:2];
  assign mode = rnd_mode_e'(mode_i);

  grs_round_decide u_decide (
    .sign_i   (sign_i),
    .mode_i   (mode),
    .guard_i  (mant_i[1]),
    .rbit_i   (mant_i[0]),
    .sticky_i (sticky_i),
    .lsb_i    (base[0]),
    .inc_o    (inc),
    .inexact_o(inx)
  );

  grs_round_incr #(.W(MANT_W)) u_incr (
    .a_i  (base),
    .inc_i(inc),
    .sum_o(mant_o)
  );

  assign round_up_o     = inc;
  assign frac_round_o   = inc;
  assign inexact_o      = inx;
  assign frac_inexact_o = inx;

  always_comb begin
    p_hold_no_inc_r9: assert (inc || mant_o == {1'b0, base})
      else $error("mantissa changed without increment");
    p_carry_top_r8: assert (!mant_o[MANT_W] || (inc && &base))
      else $error("carry-out without all-ones increment");
    p_pinf_sign_r5: assert (mode != RND_PINF || !inc || !sign_i)
      else $error("+inf mode incremented a negative value");
    p_minf_sign_r6: assert (mode != RND_MINF || !inc || sign_i)
      else $error("-inf mode incremented a positive value");
    p_inc_inexact_r2: assert (!inc || inx)
      else $error("increment on exact value");
  end
endmodule

// File: tb/grs_round_unit_tb.sv
module grs_round_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 53;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          sign_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [MW+1:0] mant_i = '0;
  logic          sticky_i = 1'b0;
  logic [MW:0]   mant_o;
  logic          round_up_o, inexact_o, frac_inexact_o, frac_round_o;

  grs_round_unit #(.MANT_W(MW)) u_dut (
    .sign_i        (sign_i),
    .mode_i        (mode_i),
    .mant_i        (mant_i),
    .sticky_i      (sticky_i),
    .mant_o        (mant_o),
    .round_up_o    (round_up_o),
    .inexact_o     (inexact_o),
    .frac_inexact_o(frac_inexact_o),
    .frac_round_o  (frac_round_o)
  );

  typedef struct {
    logic [MW:0] mant;
    logic        up;
    logic        inx;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [MW:0] act, input logic [MW:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [1:0] m,
                       input logic [MW+1:0] v, input logic st, input string tag);
    exp_t e;
    logic [MW-1:0] base;
    logic g, r, lost, inc;
    @(posedge clk);
    sign_i = s; mode_i = m; mant_i = v; sticky_i = st;
    base = v[MW+1:2];
    g = v[1]; r = v[0];
    lost = g | r | st;
    case (m)
      2'b01:   inc = 1'b0;
      2'b10:   inc = lost & ~s;
      2'b11:   inc = lost & s;
      default: inc = g & (r | st | base[0]);
    endcase
    e.mant = {1'b0, base} + {{MW{1'b0}}, inc};
    e.up = inc;
    e.inx = lost;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(mant_o == e.mant, e.tag, "mant_o", mant_o, e.mant);
        chk(round_up_o == e.up && frac_round_o == e.up, e.tag, "round_up/frac_round",
            {{(MW-1){1'b0}}, round_up_o, frac_round_o}, {{(MW-1){1'b0}}, e.up, e.up});
        chk(inexact_o == e.inx && frac_inexact_o == e.inx, e.tag, "inexact/frac_inexact",
            {{(MW-1){1'b0}}, inexact_o, frac_inexact_o}, {{(MW-1){1'b0}}, e.inx, e.inx});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [MW+1:0] ONES = '1;

  initial begin : driver
    // R1: idle/zero input, then exact values in every mode
    drive(1'b0, 2'b00, '0, 1'b0, "R1");
    for (int m = 0; m < 4; m++) drive(1'b1, 2'(m), {51'h5_a5a5_a5a5_a5a5, 4'b1100}, 1'b0, "R1");
    // R3: tie to even, tie with odd lsb, guard clear with round+sticky
    drive(1'b0, 2'b00, 55'b1000_10, 1'b0, "R3");
    drive(1'b0, 2'b00, 55'b1001_10, 1'b0, "R3");
    drive(1'b0, 2'b00, 55'b1000_01, 1'b1, "R3");
    drive(1'b0, 2'b00, 55'b1000_11, 1'b0, "R3");
    drive(1'b1, 2'b00, 55'b1000_10, 1'b1, "R3");
    // R4: toward zero with everything lost
    drive(1'b0, 2'b01, 55'b1011_11, 1'b1, "R4");
    drive(1'b1, 2'b01, ONES, 1'b1, "R4");
    // R5/R6: directed modes with both signs
    drive(1'b0, 2'b10, 55'b1000_01, 1'b0, "R5");
    drive(1'b1, 2'b10, 55'b1000_01, 1'b0, "R5");
    drive(1'b1, 2'b11, 55'b1000_00, 1'b1, "R6");
    drive(1'b0, 2'b11, 55'b1000_00, 1'b1, "R6");
    // R2 + R9: sticky only
    drive(1'b0, 2'b00, 55'b1101_00, 1'b1, "R2");
    drive(1'b0, 2'b01, 55'b1101_00, 1'b1, "R9");
    // R7: long carry ripple
    drive(1'b0, 2'b10, {2'b00, {(MW-2){1'b1}}, 2'b01}, 1'b0, "R7");
    // R8: all ones rounds to 2.0
    drive(1'b0, 2'b00, ONES, 1'b0, "R8");
    drive(1'b1, 2'b11, {ONES[MW+1:2], 2'b00}, 1'b1, "R8");
    // mixed random coverage
    for (int k = 0; k < 400; k++) begin
      logic [63:0] rv;
      rv = {$urandom(), $urandom()};
      drive(rv[63], rv[62:61], rv[MW+1:0], rv[60], "R2 R7 random");
    end
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule